// File: doc/BRIEF.md
# Partial Reconfiguration Bitstream Sequence Checker

This block stands in for the control end of a partial-reconfiguration port. A requester raises an asynchronous request line to open a session. It then presents 32-bit configuration words, one per cycle of the reconfiguration clock, each marked by a valid strobe. The block checks the word stream against a fixed framing:

- any number of all-zero filler words;
- a header word;
- a persona identifier;
- four fixed magic count words, in a fixed order.

The block reports where the session stands on a 32-bit state output drawn from a fixed event enumeration. It also drives ready, done and error flags and publishes the persona identifier once the framing reaches the first count word. A surrounding model can use this to swap the simulated contents of a region: it blanks the region while loading is under way, then selects the persona named by the identifier once the session succeeds.

If the request is withdrawn part-way through, the block names the point at which it happened. A drop before the header gives one outcome and a drop after it gives another.

Top module: `pr_seq_checker`

## Requirements
- R1: The state output uses this encoding: 0 none, 1 idle, 2 armed (waiting for header), 3 loading, 4 pass, 5 fail, 6 early withdrawal, 7 late withdrawal. While reset is held, the state is 0, ready, done and error are low, and the identifier output is zero. The first clock edge after reset moves the state to idle.
- R2: In the armed state, a valid word equal to 0x00000000 is consumed and the state stays armed.
- R3: In the armed state, a valid word equal to 0x0000A65C moves the state to loading.
- R4: In the armed state, a valid word that is neither zero nor the header moves the state to fail, and error goes high.
- R5: In loading, the first valid word is taken as the identifier. The next four valid words must be 0x01234567, 0x89ABCDEF, 0x02468ACE and 0x13579BDF, in that order. Any mismatch moves the state to fail.
- R6: When the fourth count word matches, the state moves to pass and done goes high.
- R7: The identifier output is loaded with the captured identifier on the edge that accepts a correct first count word. At all other times it holds its value, including across later sessions that fail before that point.
- R8: If the synchronized request drops in the armed state, the state moves to early withdrawal for one cycle and then to idle.
- R9: If the synchronized request drops in loading, the state moves to late withdrawal for one cycle and then to idle.
- R10: The request passes through SYNC_STAGES flops. A change on the request input is acted on by the state machine on the edge SYNC_STAGES+1 after the input changes.
- R11: Ready is high exactly in the idle, armed and loading states. A word presented with the valid strobe low has no effect.
- R12: Pass and fail hold, ignoring any further words, until the synchronized request is low. The state then returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pr_clk | input | 1 | Reconfiguration clock; words are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pr_req | input | 1 | Asynchronous session request |
| word_vld | input | 1 | Word valid strobe |
| word_in | input | 32 | Configuration word |
| ready | output | 1 | Block can take a word or a new session |
| done | output | 1 | Session finished with correct framing |
| error | output | 1 | Session finished with a framing mismatch |
| state_out | output | 32 | Event state code (see R1) |
| id_out | output | 32 | Published persona identifier |

## Verification
The bench builds the block with its default synchronizer depth of two stages. It takes that depth into its own timing as a parameter, so each wait around a request change is counted from the depth and not hard-coded. At this depth the bench can show the quiet cycles in which a dropped request has not yet reached the state machine. In those cycles a pass, fail or armed state must hold unchanged before it reacts on the third edge.

// File: rtl/pr_seq_pkg.sv
package pr_seq_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_COUNT = 4;
  localparam int unsigned PH_W      = $clog2(NUM_COUNT + 1);

  localparam logic [WORD_W-1:0] HDR_WORD = 32'h0000_A65C;
  localparam logic [WORD_W-1:0] PAD_WORD = 32'h0000_0000;

  typedef enum logic [31:0] {
    ST_NONE     = 32'd0,
    ST_IDLE     = 32'd1,
    ST_ARMED    = 32'd2,
    ST_LOADING  = 32'd3,
    ST_PASS     = 32'd4,
    ST_FAIL     = 32'd5,
    ST_WD_EARLY = 32'd6,
    ST_WD_LATE  = 32'd7
  } pr_state_e;

  // Expected count word for position idx of the magic sequence
  function automatic logic [WORD_W-1:0] count_word(input int unsigned idx);
    logic [WORD_W-1:0] w;
    case (idx)
      0:       w = 32'h0123_4567;
      1:       w = 32'h89AB_CDEF;
      2:       w = 32'h0246_8ACE;
      3:       w = 32'h1357_9BDF;
      default: w = '0;
    endcase
    return w;
  endfunction

  // Phase p (1..NUM_COUNT) expects count position p-1
  function automatic int unsigned phase_to_index(input logic [PH_W-1:0] ph);
    return (ph == '0) ? 0 : int'(ph) - 1;
  endfunction

  function automatic logic state_takes_words(input pr_state_e s);
    return (s == ST_ARMED) || (s == ST_LOADING);
  endfunction

endpackage

// File: rtl/pr_req_sync.sv
module pr_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q[0] <= 1'b0;
          else        q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q[i] <= 1'b0;
          else        q[i] <= q[i-1];
        end
        // R10: each stage repeats its predecessor one edge later
        p_stage_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
          $past(rst_n) |-> (q[i] == $past(q[i-1])));
      end
    end
  endgenerate

  assign q_sync = q[STAGES-1];

endmodule

// File: rtl/pr_word_match.sv
module pr_word_match
  import pr_seq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [PH_W-1:0]   phase,
  output logic              is_pad,
  output logic              is_hdr,
  output logic              cnt_ok
);
  logic [WORD_W-1:0] expect_w;

  always_comb begin
    expect_w = count_word(phase_to_index(phase));
    is_pad   = (word == PAD_WORD);
    is_hdr   = (word == HDR_WORD);
    cnt_ok   = (phase != '0) && (word == expect_w);
  end

endmodule

// File: rtl/pr_seq_fsm.sv
module pr_seq_fsm
  import pr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output pr_state_e         state,
  output logic              ready,
  output logic              done,
  output logic              error,
  output logic              publish,
  output logic [WORD_W-1:0] cap_id
);
  pr_state_e         st_q, st_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              is_pad, is_hdr, cnt_ok;

  // named internal events
  logic take_word;
  logic ev_pad, ev_hdr, ev_bad_hdr;
  logic ev_id_take, ev_cnt_ok, ev_cnt_bad, ev_last_cnt;
  logic ev_wd_early, ev_wd_late;

  pr_word_match u_match (
    .word   (word),
    .phase  (ph_q),
    .is_pad (is_pad),
    .is_hdr (is_hdr),
    .cnt_ok (cnt_ok)
  );

  always_comb begin
    take_word   = req_s && word_vld && state_takes_words(st_q);
    ev_pad      = take_word && (st_q == ST_ARMED) && is_pad;
    ev_hdr      = take_word && (st_q == ST_ARMED) && is_hdr;
    ev_bad_hdr  = take_word && (st_q == ST_ARMED) && !is_hdr && !is_pad;
    ev_id_take  = take_word && (st_q == ST_LOADING) && (ph_q == '0);
    ev_cnt_ok   = take_word && (st_q == ST_LOADING) && cnt_ok;
    ev_cnt_bad  = take_word && (st_q == ST_LOADING) && (ph_q != '0) && !cnt_ok;
    ev_last_cnt = ev_cnt_ok && (ph_q == PH_W'(NUM_COUNT));
    ev_wd_early = !req_s && (st_q == ST_ARMED);
    ev_wd_late  = !req_s && (st_q == ST_LOADING);
  end

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    case (st_q)
      ST_NONE: st_d = ST_IDLE;
      ST_IDLE: if (req_s) st_d = ST_ARMED;
      ST_ARMED: begin
        if (ev_wd_early)     st_d = ST_WD_EARLY;
        else if (ev_hdr)     begin st_d = ST_LOADING; ph_d = '0; end
        else if (ev_bad_hdr) st_d = ST_FAIL;
      end
      ST_LOADING: begin
        if (ev_wd_late)       st_d = ST_WD_LATE;
        else if (ev_id_take)  ph_d = PH_W'(1);
        else if (ev_last_cnt) st_d = ST_PASS;
        else if (ev_cnt_ok)   ph_d = ph_q + PH_W'(1);
        else if (ev_cnt_bad)  st_d = ST_FAIL;
      end
      ST_PASS, ST_FAIL: if (!req_s) st_d = ST_IDLE;
      ST_WD_EARLY, ST_WD_LATE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_NONE;
      ph_q   <= '0;
      cap_id <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (ev_id_take) cap_id <= word;
    end
  end

  assign state   = st_q;
  assign ready   = (st_q == ST_IDLE) || state_takes_words(st_q);
  assign done    = (st_q == ST_PASS);
  assign error   = (st_q == ST_FAIL);
  assign publish = ev_cnt_ok && (ph_q == PH_W'(1));

  // R2: filler keeps the block armed
  p_pad_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pad |=> (st_q == ST_ARMED));
  // R3: header opens loading
  p_hdr_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr |=> (st_q == ST_LOADING) && (ph_q == '0));
  // R4: wrong header word fails the session
  p_bad_hdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_hdr |=> error);
  // R5: wrong count word fails the session
  p_bad_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cnt_bad |=> error);
  // R6: last count word finishes the session
  p_last_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_cnt |=> done);
  // R8: early withdrawal
  p_wd_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wd_early |=> (st_q == ST_WD_EARLY));
  // R9: late withdrawal
  p_wd_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wd_late |=> (st_q == ST_WD_LATE));
  // R9: withdrawal outcomes last one cycle
  p_wd_brief_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WD_EARLY) || (st_q == ST_WD_LATE)) |=> (st_q == ST_IDLE));
  // R11: no strobe, no progress
  p_no_vld_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_takes_words(st_q) && req_s && !word_vld) |=> ($stable(st_q) && $stable(ph_q)));
  // R12: terminal outcomes hold while requested
  p_end_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || error) && req_s) |=> $stable(st_q));
  // R1: flags never overlap
  p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, done, error}));

endmodule

// File: rtl/pr_id_out.sv
module pr_id_out
  import pr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              publish,
  input  logic [WORD_W-1:0] cap_id,
  output logic [WORD_W-1:0] id_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       id_q <= '0;
    else if (publish) id_q <= cap_id;
  end

  // R7: identifier changes only on publication
  p_id_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !publish |=> $stable(id_q));
  p_id_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> (id_q == $past(cap_id)));

endmodule

// File: rtl/pr_seq_checker.sv
module pr_seq_checker
  import pr_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        pr_clk,
  input  logic        rst_n,
  input  logic        pr_req,
  input  logic        word_vld,
  input  logic [31:0] word_in,
  output logic        ready,
  output logic        done,
  output logic        error,
  output logic [31:0] state_out,
  output logic [31:0] id_out
);
  logic              req_s;
  logic              publish;
  logic [WORD_W-1:0] cap_id;
  pr_state_e         state;

  pr_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (pr_clk),
    .rst_n   (rst_n),
    .d_async (pr_req),
    .q_sync  (req_s)
  );

  pr_seq_fsm u_fsm (
    .clk      (pr_clk),
    .rst_n    (rst_n),
    .req_s    (req_s),
    .word_vld (word_vld),
    .word     (word_in),
    .state    (state),
    .ready    (ready),
    .done     (done),
    .error    (error),
    .publish  (publish),
    .cap_id   (cap_id)
  );

  pr_id_out u_id (
    .clk     (pr_clk),
    .rst_n   (rst_n),
    .publish (publish),
    .cap_id  (cap_id),
    .id_q    (id_out)
  );

  assign state_out = state;

endmodule

// File: tb/pr_seq_checker_tb.sv
module pr_seq_checker_tb;
  localparam int unsigned SYNC = 2;

  localparam logic [31:0] S_NONE = 0, S_IDLE = 1, S_ARMED = 2, S_LOAD = 3,
                          S_PASS = 4, S_FAIL = 5, S_WDE = 6, S_WDL = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] din = '0;
  logic        ready, done, error;
  logic [31:0] state_out, id_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pr_seq_checker #(.SYNC_STAGES(SYNC)) u_dut (
    .pr_clk    (clk),
    .rst_n     (rst_n),
    .pr_req    (req),
    .word_vld  (vld),
    .word_in   (din),
    .ready     (ready),
    .done      (done),
    .error     (error),
    .state_out (state_out),
    .id_out    (id_out)
  );

  typedef struct packed {
    logic        v;
    logic [31:0] d;
    logic [31:0] st;
    logic [31:0] id;
  } vec_t;

  // one full session with filler, gaps and a trailing ignored word
  localparam vec_t VECS [12] = '{
    '{1'b0, 32'h0000_0000, 32'd2, 32'h0},           // R11 gap
    '{1'b1, 32'h0000_0000, 32'd2, 32'h0},           // R2 filler
    '{1'b1, 32'h0000_0000, 32'd2, 32'h0},           // R2 filler
    '{1'b0, 32'h0000_A65C, 32'd2, 32'h0},           // R11 header without strobe
    '{1'b1, 32'h0000_A65C, 32'd3, 32'h0},           // R3
    '{1'b1, 32'hCAFE_0001, 32'd3, 32'h0},           // R5 id taken, R7 not yet out
    '{1'b0, 32'h0123_4567, 32'd3, 32'h0},           // R11
    '{1'b1, 32'h0123_4567, 32'd3, 32'hCAFE_0001},   // R7 published
    '{1'b1, 32'h89AB_CDEF, 32'd3, 32'hCAFE_0001},   // R5
    '{1'b1, 32'h0246_8ACE, 32'd3, 32'hCAFE_0001},   // R5
    '{1'b1, 32'h1357_9BDF, 32'd4, 32'hCAFE_0001},   // R6
    '{1'b1, 32'hDEAD_BEEF, 32'd4, 32'hCAFE_0001}    // R12 ignored
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [31:0] st, input logic [31:0] id);
    chk({tag, " state"}, state_out, st);
    chk({"R11 ready ", tag}, {31'b0, ready}, {31'b0, (st == S_IDLE) || (st == S_ARMED) || (st == S_LOAD)});
    chk({"R6 done ", tag}, {31'b0, done}, {31'b0, st == S_PASS});
    chk({"R4 error ", tag}, {31'b0, error}, {31'b0, st == S_FAIL});
    chk({"R7 id ", tag}, id_out, id);
  endtask

  task automatic word(input logic [31:0] w);
    vld = 1'b1;
    din = w;
    tick();
    vld = 1'b0;
    din = '0;
  endtask

  // request goes high; held for SYNC edges, acted on the next (R10)
  task automatic open_session(input logic [31:0] id);
    req = 1'b1;
    repeat (SYNC) tick();
    chk_all("R10 rise held", S_IDLE, id);
    tick();
    chk_all("R10 rise acted", S_ARMED, id);
  endtask

  task automatic close_session(input string tag, input logic [31:0] held,
                               input logic [31:0] after, input logic [31:0] id);
    req = 1'b0;
    repeat (SYNC) tick();
    chk_all({tag, " before drop seen"}, held, id);
    tick();
    chk_all({tag, " after drop"}, after, id);
    if (after != S_IDLE) begin
      tick();
      chk_all({tag, " back to idle"}, S_IDLE, id);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    chk_all("R1 in reset", S_NONE, 32'h0);
    rst_n = 1'b1;
    tick();
    chk_all("R1 first edge", S_IDLE, 32'h0);
    tick();
    chk_all("R1 idle holds", S_IDLE, 32'h0);

    // table-driven session
    open_session(32'h0);
    for (int i = 0; i < 12; i++) begin
      vld = VECS[i].v;
      din = VECS[i].d;
      tick();
      chk_all($sformatf("R5 vec%0d", i), VECS[i].st, VECS[i].id);
    end
    vld = 1'b0;
    close_session("R12 pass", S_PASS, S_IDLE, 32'hCAFE_0001);

    // wrong header
    open_session(32'hCAFE_0001);
    word(32'h0000_0000);
    word(32'h0000_A65D);
    chk_all("R4 bad header", S_FAIL, 32'hCAFE_0001);
    word(32'h0000_A65C);
    chk_all("R12 fail ignores", S_FAIL, 32'hCAFE_0001);
    close_session("R12 fail", S_FAIL, S_IDLE, 32'hCAFE_0001);

    // wrong second count word: id published, then failure
    open_session(32'hCAFE_0001);
    word(32'h0000_A65C);
    word(32'h1111_2222);
    chk_all("R7 id held", S_LOAD, 32'hCAFE_0001);
    word(32'h0123_4567);
    chk_all("R7 new id", S_LOAD, 32'h1111_2222);
    word(32'h89AB_CDEE);
    chk_all("R5 bad count", S_FAIL, 32'h1111_2222);
    close_session("R5 fail", S_FAIL, S_IDLE, 32'h1111_2222);

    // counts out of order at the first position: id not published
    open_session(32'h1111_2222);
    word(32'h0000_A65C);
    word(32'h3333_4444);
    word(32'h89AB_CDEF);
    chk_all("R5 order", S_FAIL, 32'h1111_2222);
    close_session("R7 unpublished", S_FAIL, S_IDLE, 32'h1111_2222);

    // early withdrawal
    open_session(32'h1111_2222);
    word(32'h0000_0000);
    close_session("R8 early", S_ARMED, S_WDE, 32'h1111_2222);

    // late withdrawal after header and id
    open_session(32'h1111_2222);
    word(32'h0000_A65C);
    word(32'h5555_6666);
    close_session("R9 late", S_LOAD, S_WDL, 32'h1111_2222);

    // reset mid-session
    open_session(32'h1111_2222);
    word(32'h0000_A65C);
    rst_n = 1'b0;
    tick();
    chk_all("R1 reset again", S_NONE, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule